// File: doc/BRIEF.md
# UART Transmit Buffer DMA Engine

The engine moves a software-prepared byte buffer from memory to a UART transmitter. Software fills in one or two buffer slots: a 64-bit pointer, a data length and a status word. It then writes the overall transfer length, clears the empty flag of each slot it wants sent, and sets the enable bit. The engine fetches bytes one at a time through a simple byte-read port and hands each byte to the transmitter over a ready/valid handshake. Every accepted byte advances a per-slot sent counter and a transfer-wide total, and software can read both.

A slot is closed when its sent count reaches its data length, or when the transfer total reaches the transfer length. Closing a slot sets its empty flag and raises that slot's empty event. The transfer finishes when the closed slot carries the last flag, is the final slot in use, or the transfer length has been reached. On finishing, the engine raises the done event and clears enable by itself. Writing the abort bit while enabled stops the transfer at once and raises the abort event.

The sequencer has five states. IDLE leaves for PICK when enable is set. PICK moves to CLOSE when the transfer length is reached or the slot is drained. PICK holds while the current slot is still marked empty, and otherwise goes to READ. READ holds the memory request and moves to SEND when the byte returns. SEND holds the byte until the transmitter accepts it. It then goes to CLOSE if that byte ends the slot or the transfer, and back to READ otherwise. CLOSE returns to IDLE when the transfer finishes and advances to PICK on the next slot otherwise. From any state, a cleared enable forces IDLE.

Top module: `uart_txbuf_dma`

## Requirements

Register byte offsets are as follows:
- control 0x00
- transfer length 0x04
- transfer total sent 0x08, read only

Slot s starts at 0x20+0x14*s and holds these words:
- pointer low at +0x00
- pointer high at +0x04
- status at +0x08
- data length at +0x0C
- sent count at +0x10, read only

Control bits:
- bit0 enable
- bit1 abort, reads 0
- bits 5:4 number of slots used (0 or 1 means one slot, 2 means two)
- bit6 endian
- bit7 endian override

Status bits: bit0 empty, bit1 last.

Event bits: evt[0] done, evt[1] abort, evt[2] all used slots empty, evt[3+s] slot s empty. Each event is a one-cycle pulse.

- R1: After reset the control register reads 0x10 (enable 0, slot count 1), every slot status reads empty=1, every sent count and the total read 0, and tx_valid, mem_rd_en and evt are all 0.
- R2: With byte swap off, the bytes of a slot reach the transmitter in order. Byte i is the memory byte at pointer+i, and one byte is delivered per tx_valid/tx_ready handshake.
- R3: When control bit7 and bit6 are both 1, the low two address bits of every fetch are inverted. When bit7 is 0, bit6 has no effect.
- R4: The slot sent count and the transfer total rise by one for each accepted byte. A write that sets enable while the engine is disabled zeroes them.
- R5: When a slot's sent count reaches its data length and that slot finishes the transfer, the engine sets the slot's empty flag, pulses the slot-empty and done events, and clears enable.
- R6: When the total reaches the transfer length partway through a slot, transmission stops, the slot is closed and done is raised.
- R7: With two slots in use, slot 0 is sent and then slot 1, with a single done at the end. A last flag on slot 0 ends the transfer after slot 0 and leaves slot 1 untouched.
- R8: While the current slot's empty flag is 1, the engine issues no memory read and no tx_valid. It starts once software clears the flag.
- R9: A control write with abort=1 while enabled clears enable, pulses the abort event on the next cycle, and drops tx_valid. Abort while disabled raises no event.
- R10: The all-empty event pulses together with a slot-empty event, and only when every slot in use is empty after that close.
- R11: Once tx_valid is raised, it stays high with tx_data unchanged until tx_ready, unless the transfer is stopped.
- R12: A slot whose data length is 0 closes without fetching or sending a byte.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register write byte offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 8 | Register read byte offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| mem_rd_en | output | 1 | Byte read request, held until mem_rvalid |
| mem_addr | output | 64 | Byte address of the read |
| mem_rdata | input | 8 | Returned byte |
| mem_rvalid | input | 1 | Returned byte is valid |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter accepts the byte |
| evt | output | 5 | Event pulses: done, abort, all empty, slot 0 empty, slot 1 empty |

## Verification

The bench covers several corner cases, each with the failure it would expose:
- A transfer length shorter than the slot would, if ignored, send extra bytes.
- A restart that leaves the counters alone would read back sums carried over from the previous transfer.
- The override bit gating the endian bit: a design that swaps on the endian bit alone scrambles byte order in a mode that must not.
- A slot whose empty flag is still set must get no fetch; a design that skipped the wait would send garbage.
- A last flag on slot 0 that was ignored would drain slot 1 as well.
- Abort must stop traffic at once, and the same write while idle must not raise a phantom abort event.
- Random transmitter stalls exercise handshake hold-off; a design that changed tx_data before acceptance would drop or duplicate bytes.

// File: rtl/uart_txbuf_dma_pkg.sv
package uart_txbuf_dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PICK  = 3'd1,
        ST_READ  = 3'd2,
        ST_SEND  = 3'd3,
        ST_CLOSE = 3'd4
    } txdma_state_e;

    localparam int CTRL_OFS    = 'h00;
    localparam int XLEN_OFS    = 'h04;
    localparam int TOTAL_OFS   = 'h08;
    localparam int SLOT_BASE   = 'h20;
    localparam int SLOT_STRIDE = 'h14;

    localparam int F_PTR_LO = 'h00;
    localparam int F_PTR_HI = 'h04;
    localparam int F_STAT   = 'h08;
    localparam int F_LEN    = 'h0C;
    localparam int F_SENT   = 'h10;

    localparam int CB_EN     = 0;
    localparam int CB_ABORT  = 1;
    localparam int CB_NB_LO  = 4;
    localparam int CB_ENDIAN = 6;
    localparam int CB_OVR    = 7;

    localparam int EVT_DONE  = 0;
    localparam int EVT_ABORT = 1;
    localparam int EVT_ALL   = 2;
    localparam int EVT_SLOT0 = 3;

endpackage

// File: rtl/uart_txbuf_dma_regs.sv
module uart_txbuf_dma_regs
    import uart_txbuf_dma_pkg::*;
#(
    parameter int NUM_SLOTS    = 2,
    parameter int LEN_W        = 16,
    parameter int AW           = 8,
    parameter bit DEFAULT_SWAP = 1'b0,
    localparam int SW   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int NB_W = $clog2(NUM_SLOTS + 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [AW-1:0]                     wr_addr,
    input  logic [31:0]                       wr_data,
    input  logic [AW-1:0]                     rd_addr,
    output logic [31:0]                       rd_data,
    input  logic                              byte_ack,
    input  logic [SW-1:0]                     act_slot,
    input  logic                              close_slot,
    input  logic                              fin,
    output logic                              en,
    output logic [NB_W-1:0]                   nbuf_used,
    output logic                              swap,
    output logic [LEN_W-1:0]                  xfer_len,
    output logic [LEN_W-1:0]                  total,
    output logic [NUM_SLOTS-1:0][63:0]        slot_ptr,
    output logic [NUM_SLOTS-1:0][LEN_W-1:0]   slot_len,
    output logic [NUM_SLOTS-1:0][LEN_W-1:0]   slot_sent,
    output logic [NUM_SLOTS-1:0]              slot_empty,
    output logic [NUM_SLOTS-1:0]              slot_last,
    output logic                              abort_evt
);

    logic [1:0] nb_q;
    logic       endian_q;
    logic       ovr_q;
    logic       ctrl_wr;
    logic       start;

    function automatic logic [AW-1:0] slot_reg(input int s, input int f);
        return AW'(SLOT_BASE + s * SLOT_STRIDE + f);
    endfunction

    assign ctrl_wr = wr_en && (wr_addr == AW'(CTRL_OFS));
    assign start   = ctrl_wr && wr_data[CB_EN] && !wr_data[CB_ABORT] && !en;
    assign swap    = ovr_q ? endian_q : DEFAULT_SWAP;

    always_comb begin
        if (nb_q == 2'd0) begin
            nbuf_used = NB_W'(1);
        end else if (int'(nb_q) > NUM_SLOTS) begin
            nbuf_used = NB_W'(NUM_SLOTS);
        end else begin
            nbuf_used = NB_W'(nb_q);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en        <= 1'b0;
            nb_q      <= 2'd1;
            endian_q  <= 1'b0;
            ovr_q     <= 1'b0;
            xfer_len  <= '0;
            total     <= '0;
            abort_evt <= 1'b0;
            for (int s = 0; s < NUM_SLOTS; s++) begin
                slot_ptr[s]   <= '0;
                slot_len[s]   <= '0;
                slot_sent[s]  <= '0;
                slot_empty[s] <= 1'b1;
                slot_last[s]  <= 1'b0;
            end
        end else begin
            abort_evt <= ctrl_wr && wr_data[CB_ABORT] && en;
            if (ctrl_wr) begin
                nb_q     <= wr_data[CB_NB_LO+1:CB_NB_LO];
                endian_q <= wr_data[CB_ENDIAN];
                ovr_q    <= wr_data[CB_OVR];
                if (wr_data[CB_ABORT] && en) begin
                    en <= 1'b0;
                end else begin
                    en <= wr_data[CB_EN];
                end
            end else if (fin) begin
                en <= 1'b0;
            end
            if (wr_en && wr_addr == AW'(XLEN_OFS)) begin
                xfer_len <= wr_data[LEN_W-1:0];
            end
            if (start) begin
                total <= '0;
            end else if (byte_ack) begin
                total <= total + LEN_W'(1);
            end
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (wr_en && wr_addr == slot_reg(s, F_PTR_LO)) begin
                    slot_ptr[s][31:0] <= wr_data;
                end
                if (wr_en && wr_addr == slot_reg(s, F_PTR_HI)) begin
                    slot_ptr[s][63:32] <= wr_data;
                end
                if (wr_en && wr_addr == slot_reg(s, F_LEN)) begin
                    slot_len[s] <= wr_data[LEN_W-1:0];
                end
                if (wr_en && wr_addr == slot_reg(s, F_STAT)) begin
                    slot_empty[s] <= wr_data[0];
                    slot_last[s]  <= wr_data[1];
                end
                if (close_slot && int'(act_slot) == s) begin
                    slot_empty[s] <= 1'b1;
                end
                if (start) begin
                    slot_sent[s] <= '0;
                end else if (byte_ack && int'(act_slot) == s) begin
                    slot_sent[s] <= slot_sent[s] + LEN_W'(1);
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(CTRL_OFS)) begin
            rd_data = {24'd0, ovr_q, endian_q, nb_q, 3'b000, en};
        end else if (rd_addr == AW'(XLEN_OFS)) begin
            rd_data = 32'(xfer_len);
        end else if (rd_addr == AW'(TOTAL_OFS)) begin
            rd_data = 32'(total);
        end
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (rd_addr == slot_reg(s, F_PTR_LO)) rd_data = slot_ptr[s][31:0];
            if (rd_addr == slot_reg(s, F_PTR_HI)) rd_data = slot_ptr[s][63:32];
            if (rd_addr == slot_reg(s, F_STAT))   rd_data = {30'd0, slot_last[s], slot_empty[s]};
            if (rd_addr == slot_reg(s, F_LEN))    rd_data = 32'(slot_len[s]);
            if (rd_addr == slot_reg(s, F_SENT))   rd_data = 32'(slot_sent[s]);
        end
    end

    // R4
    total_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ack |=> (total == $past(total) + LEN_W'(1)));

    // R9
    abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_data[CB_ABORT] && en) |=> (!en && abort_evt));

    // R5
    finish_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !ctrl_wr) |=> !en);

endmodule

// File: rtl/uart_txbuf_dma_agen.sv
module uart_txbuf_dma_agen #(
    parameter int LEN_W = 16
) (
    input  logic [63:0]      base,
    input  logic [LEN_W-1:0] offset,
    input  logic             swap,
    output logic [63:0]      addr
);

    logic [63:0] linear;

    assign linear = base + 64'(offset);

    always_comb begin
        addr = linear;
        if (swap) begin
            addr[1:0] = ~linear[1:0];
        end
    end

endmodule

// File: rtl/uart_txbuf_dma_fsm.sv
module uart_txbuf_dma_fsm
    import uart_txbuf_dma_pkg::*;
#(
    parameter int NUM_SLOTS = 2,
    parameter int LEN_W     = 16,
    localparam int SW   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int NB_W = $clog2(NUM_SLOTS + 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              en,
    input  logic [NB_W-1:0]                   nbuf_used,
    input  logic                              swap,
    input  logic [LEN_W-1:0]                  xfer_len,
    input  logic [LEN_W-1:0]                  total,
    input  logic [NUM_SLOTS-1:0][63:0]        slot_ptr,
    input  logic [NUM_SLOTS-1:0][LEN_W-1:0]   slot_len,
    input  logic [NUM_SLOTS-1:0][LEN_W-1:0]   slot_sent,
    input  logic [NUM_SLOTS-1:0]              slot_empty,
    input  logic [NUM_SLOTS-1:0]              slot_last,
    output logic                              mem_rd_en,
    output logic [63:0]                       mem_addr,
    input  logic [7:0]                        mem_rdata,
    input  logic                              mem_rvalid,
    output logic                              tx_valid,
    output logic [7:0]                        tx_data,
    input  logic                              tx_ready,
    output logic                              byte_ack,
    output logic [SW-1:0]                     act_slot,
    output logic                              close_slot,
    output logic                              fin,
    output logic [NUM_SLOTS-1:0]              evt_slot_empty,
    output logic                              evt_all_empty
);

    txdma_state_e state_q, state_d;
    logic [SW-1:0] cur_q;
    logic [7:0]    data_q;

    logic             cur_empty;
    logic             cur_last;
    logic [LEN_W-1:0] cur_len;
    logic [LEN_W-1:0] cur_sent;
    logic             cur_final;
    logic             reached;
    logic             finish;

    assign cur_empty = slot_empty[cur_q];
    assign cur_last  = slot_last[cur_q];
    assign cur_len   = slot_len[cur_q];
    assign cur_sent  = slot_sent[cur_q];
    assign cur_final = (int'(cur_q) == int'(nbuf_used) - 1);
    assign reached   = (total == xfer_len);
    assign finish    = cur_last || cur_final || reached;

    uart_txbuf_dma_agen #(.LEN_W(LEN_W)) u_agen (
        .base   (slot_ptr[cur_q]),
        .offset (cur_sent),
        .swap   (swap),
        .addr   (mem_addr)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en) state_d = ST_PICK;
            end
            ST_PICK: begin
                if (reached) begin
                    state_d = ST_CLOSE;
                end else if (cur_empty) begin
                    state_d = ST_PICK;
                end else if (cur_sent == cur_len) begin
                    state_d = ST_CLOSE;
                end else begin
                    state_d = ST_READ;
                end
            end
            ST_READ: begin
                if (mem_rvalid) state_d = ST_SEND;
            end
            ST_SEND: begin
                if (tx_ready) begin
                    if ((total + LEN_W'(1) == xfer_len) ||
                        (cur_sent + LEN_W'(1) == cur_len)) begin
                        state_d = ST_CLOSE;
                    end else begin
                        state_d = ST_READ;
                    end
                end
            end
            ST_CLOSE: begin
                state_d = finish ? ST_IDLE : ST_PICK;
            end
            default: state_d = ST_IDLE;
        endcase
        if (!en) begin
            state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                cur_q <= '0;
            end else if (state_q == ST_CLOSE && !finish) begin
                cur_q <= SW'(cur_q + 1'b1);
            end
            if (state_q == ST_READ && mem_rvalid) begin
                data_q <= mem_rdata;
            end
        end
    end

    always_comb begin
        mem_rd_en     = en && (state_q == ST_READ);
        tx_valid      = en && (state_q == ST_SEND);
        tx_data       = data_q;
        byte_ack      = tx_valid && tx_ready;
        act_slot      = cur_q;
        close_slot    = en && (state_q == ST_CLOSE);
        fin           = close_slot && finish;
        evt_all_empty = close_slot;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            evt_slot_empty[s] = close_slot && (int'(cur_q) == s);
            if (s < int'(nbuf_used) && s != int'(cur_q) && !slot_empty[s]) begin
                evt_all_empty = 1'b0;
            end
        end
    end

    // R11
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> ((tx_valid && $stable(tx_data)) || !en));

    // R8
    wait_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PICK && cur_empty && !reached) |=> !tx_valid);

endmodule

// File: rtl/uart_txbuf_dma.sv
module uart_txbuf_dma
    import uart_txbuf_dma_pkg::*;
#(
    parameter int NUM_SLOTS    = 2,
    parameter int LEN_W        = 16,
    parameter int AW           = 8,
    parameter bit DEFAULT_SWAP = 1'b0,
    localparam int EVT_W = 3 + NUM_SLOTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [AW-1:0]    reg_wr_addr,
    input  logic [31:0]      reg_wr_data,
    input  logic [AW-1:0]    reg_rd_addr,
    output logic [31:0]      reg_rd_data,
    output logic             mem_rd_en,
    output logic [63:0]      mem_addr,
    input  logic [7:0]       mem_rdata,
    input  logic             mem_rvalid,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    input  logic             tx_ready,
    output logic [EVT_W-1:0] evt
);

    localparam int SW   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam int NB_W = $clog2(NUM_SLOTS + 1);

    logic                            en;
    logic [NB_W-1:0]                 nbuf_used;
    logic                            swap;
    logic [LEN_W-1:0]                xfer_len;
    logic [LEN_W-1:0]                total;
    logic [NUM_SLOTS-1:0][63:0]      slot_ptr;
    logic [NUM_SLOTS-1:0][LEN_W-1:0] slot_len;
    logic [NUM_SLOTS-1:0][LEN_W-1:0] slot_sent;
    logic [NUM_SLOTS-1:0]            slot_empty;
    logic [NUM_SLOTS-1:0]            slot_last;
    logic                            abort_evt;
    logic                            byte_ack;
    logic [SW-1:0]                   act_slot;
    logic                            close_slot;
    logic                            fin;
    logic [NUM_SLOTS-1:0]            evt_slot_empty;
    logic                            evt_all_empty;

    uart_txbuf_dma_regs #(
        .NUM_SLOTS    (NUM_SLOTS),
        .LEN_W        (LEN_W),
        .AW           (AW),
        .DEFAULT_SWAP (DEFAULT_SWAP)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .wr_addr    (reg_wr_addr),
        .wr_data    (reg_wr_data),
        .rd_addr    (reg_rd_addr),
        .rd_data    (reg_rd_data),
        .byte_ack   (byte_ack),
        .act_slot   (act_slot),
        .close_slot (close_slot),
        .fin        (fin),
        .en         (en),
        .nbuf_used  (nbuf_used),
        .swap       (swap),
        .xfer_len   (xfer_len),
        .total      (total),
        .slot_ptr   (slot_ptr),
        .slot_len   (slot_len),
        .slot_sent  (slot_sent),
        .slot_empty (slot_empty),
        .slot_last  (slot_last),
        .abort_evt  (abort_evt)
    );

    uart_txbuf_dma_fsm #(
        .NUM_SLOTS (NUM_SLOTS),
        .LEN_W     (LEN_W)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .en             (en),
        .nbuf_used      (nbuf_used),
        .swap           (swap),
        .xfer_len       (xfer_len),
        .total          (total),
        .slot_ptr       (slot_ptr),
        .slot_len       (slot_len),
        .slot_sent      (slot_sent),
        .slot_empty     (slot_empty),
        .slot_last      (slot_last),
        .mem_rd_en      (mem_rd_en),
        .mem_addr       (mem_addr),
        .mem_rdata      (mem_rdata),
        .mem_rvalid     (mem_rvalid),
        .tx_valid       (tx_valid),
        .tx_data        (tx_data),
        .tx_ready       (tx_ready),
        .byte_ack       (byte_ack),
        .act_slot       (act_slot),
        .close_slot     (close_slot),
        .fin            (fin),
        .evt_slot_empty (evt_slot_empty),
        .evt_all_empty  (evt_all_empty)
    );

    assign evt = {evt_slot_empty, evt_all_empty, abort_evt, fin};

    // R10
    all_empty_with_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt[EVT_ALL] |-> ($countones(evt[EVT_W-1:EVT_SLOT0]) == 1));

endmodule

// File: tb/uart_txbuf_dma_test.sv
module uart_txbuf_dma_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic [7:0]  reg_rd_addr = '0;
    logic [31:0] reg_rd_data;
    logic        mem_rd_en;
    logic [63:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic [4:0]  evt;

    uart_txbuf_dma uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_addr (reg_wr_addr),
        .reg_wr_data (reg_wr_data),
        .reg_rd_addr (reg_rd_addr),
        .reg_rd_data (reg_rd_data),
        .mem_rd_en   (mem_rd_en),
        .mem_addr    (mem_addr),
        .mem_rdata   (mem_rdata),
        .mem_rvalid  (mem_rvalid),
        .tx_valid    (tx_valid),
        .tx_data     (tx_data),
        .tx_ready    (tx_ready),
        .evt         (evt)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0] cap [0:1023];
    int cap_n = 0;
    int mem_reads = 0;
    int mem_dly = 0;
    int done_cnt = 0, abort_cnt = 0, all_cnt = 0, s0_cnt = 0, s1_cnt = 0;
    bit slow_ready = 0;
    bit skip_hold = 0;
    bit hold_pend = 0;
    logic [7:0] hold_data = '0;
    int hold_checks = 0, hold_bad = 0;

    function automatic logic [7:0] memf(input logic [63:0] a);
        return a[7:0] ^ a[15:8] ^ a[39:32] ^ 8'h3C;
    endfunction

    function automatic logic [63:0] exp_addr(input logic [63:0] p, input int i, input bit sw);
        logic [63:0] e;
        e = p + 64'(i);
        if (sw) e[1:0] = ~e[1:0];
        return e;
    endfunction

    function automatic logic [7:0] slot_reg(input int s, input int f);
        return 8'(32'h20 + s * 32'h14 + f);
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (slow_ready) tx_ready = ($urandom % 8) == 0;
            else            tx_ready = ($urandom % 4) != 0;
            if (hold_pend && !skip_hold) begin
                hold_checks++;
                if (!tx_valid || tx_data != hold_data) hold_bad++;
            end
            hold_pend = tx_valid && !tx_ready;
            hold_data = tx_data;
            if (tx_valid && tx_ready && cap_n < 1024) begin
                cap[cap_n] = tx_data;
                cap_n++;
            end
            if (mem_rvalid) begin
                mem_rvalid = 1'b0;
                mem_dly = $urandom % 3;
            end else if (mem_rd_en) begin
                if (mem_dly == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata = memf(mem_addr);
                    mem_reads++;
                end else begin
                    mem_dly--;
                end
            end
            if (evt[0]) done_cnt++;
            if (evt[1]) abort_cnt++;
            if (evt[2]) all_cnt++;
            if (evt[3]) s0_cnt++;
            if (evt[4]) s1_cnt++;
        end
    end

    task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wr_addr = a;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_addr = a;
        #1;
        d = reg_rd_data;
    endtask

    task automatic wait_done(input int d0, input string tag);
        int n = 0;
        while (done_cnt == d0 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (done_cnt == d0) check_eq({tag, " done timeout"}, 0, 1);
        repeat (2) @(negedge clk);
    endtask

    task automatic setup_slot(input int s, input logic [63:0] p, input int len, input logic [31:0] stat);
        reg_write(slot_reg(s, 'h00), p[31:0]);
        reg_write(slot_reg(s, 'h04), p[63:32]);
        reg_write(slot_reg(s, 'h0C), 32'(len));
        reg_write(slot_reg(s, 'h08), stat);
    endtask

    task automatic cmp_bytes(input string tag, input int base, input logic [63:0] p,
                             input int first, input int n, input bit sw);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            if (cap[base + i] !== memf(exp_addr(p, first + i, sw))) bad++;
        end
        check_eq({tag, " byte mismatches"}, 64'(bad), 0);
    endtask

    task automatic run_single(input logic [63:0] p, input int len, input int xl, input int mode);
        int base, d0, a0, s00, n;
        bit sw;
        logic [31:0] r;
        string tag;
        base = cap_n; d0 = done_cnt; a0 = all_cnt; s00 = s0_cnt;
        sw = (mode == 3);
        tag = sw ? "R3" : "R2";
        n = (len < xl) ? len : xl;
        setup_slot(0, p, len, 32'h0);
        reg_write(8'h04, 32'(xl));
        reg_write(8'h00, 32'h11 | ((mode & 1) << 6) | ((mode >> 1) << 7));
        wait_done(d0, "R5");
        check_eq({tag, " byte count"}, 64'(cap_n - base), 64'(n));
        cmp_bytes(tag, base, p, 0, n, sw);
        reg_read(slot_reg(0, 'h10), r);
        check_eq("R4 slot sent", 64'(r), 64'(n));
        reg_read(8'h08, r);
        check_eq("R4 total", 64'(r), 64'(n));
        reg_read(slot_reg(0, 'h08), r);
        check_eq((xl < len) ? "R6 empty after stop" : "R5 empty set", 64'(r[0]), 1);
        reg_read(8'h00, r);
        check_eq("R5 enable cleared", 64'(r[0]), 0);
        check_eq("R5 done count", 64'(done_cnt), 64'(d0 + 1));
        check_eq("R5 slot0 empty event", 64'(s0_cnt), 64'(s00 + 1));
        check_eq("R10 all empty single slot", 64'(all_cnt), 64'(a0 + 1));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        int base, d0, a0, s00, s10, ab0, r0, k;
        logic [63:0] pa, pb;
        void'($urandom(32'h00C0FFEE));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_read(8'h00, r);           check_eq("R1 ctrl reset", 64'(r), 64'h10);
        reg_read(slot_reg(0, 'h08), r); check_eq("R1 slot0 status", 64'(r), 1);
        reg_read(slot_reg(1, 'h08), r); check_eq("R1 slot1 status", 64'(r), 1);
        reg_read(slot_reg(0, 'h10), r); check_eq("R1 slot0 sent", 64'(r), 0);
        reg_read(8'h08, r);           check_eq("R1 total", 64'(r), 0);
        check_eq("R1 outputs idle", {61'd0, tx_valid, mem_rd_en, |evt}, 0);

        // R2 R3 R4 R5 R6 random transfers across endian modes
        for (int t = 0; t < 10; t++) begin
            logic [63:0] p;
            int len, xl;
            p = {$urandom, $urandom};
            len = 1 + ($urandom % 20);
            xl = (($urandom % 3) == 0) ? 1 + ($urandom % len) : 1000;
            run_single(p, len, xl, t % 4);
        end

        // R3 directed: override set, endian set, aligned pointer
        run_single(64'h0000_0012_0000_0100, 8, 100, 3);
        // R6 directed: transfer length cuts slot short
        run_single(64'h0000_0000_0000_2000, 10, 4, 0);

        // R12 zero-length slot
        base = cap_n; d0 = done_cnt; r0 = mem_reads;
        setup_slot(0, 64'h5000, 0, 32'h0);
        reg_write(8'h04, 32'd50);
        reg_write(8'h00, 32'h11);
        wait_done(d0, "R12");
        check_eq("R12 no bytes", 64'(cap_n - base), 0);
        check_eq("R12 no fetch", 64'(mem_reads - r0), 0);
        reg_read(slot_reg(0, 'h08), r); check_eq("R12 empty set", 64'(r[0]), 1);

        // R7 two slots in sequence
        pa = 64'h0000_0001_0000_0040; pb = 64'h0000_0002_0000_0080;
        base = cap_n; d0 = done_cnt; a0 = all_cnt; s00 = s0_cnt; s10 = s1_cnt;
        setup_slot(0, pa, 3, 32'h0);
        setup_slot(1, pb, 4, 32'h0);
        reg_write(8'h04, 32'd100);
        reg_write(8'h00, 32'h21);
        wait_done(d0, "R7");
        check_eq("R7 two-slot byte count", 64'(cap_n - base), 7);
        cmp_bytes("R7 slot0", base, pa, 0, 3, 0);
        cmp_bytes("R7 slot1", base + 3, pb, 0, 4, 0);
        reg_read(slot_reg(1, 'h10), r); check_eq("R7 slot1 sent", 64'(r), 4);
        reg_read(8'h08, r);           check_eq("R7 total", 64'(r), 7);
        check_eq("R7 single done", 64'(done_cnt), 64'(d0 + 1));
        check_eq("R7 slot events", 64'((s0_cnt - s00) * 16 + (s1_cnt - s10)), 64'h11);
        check_eq("R10 all empty once", 64'(all_cnt), 64'(a0 + 1));

        // R7 R10 last flag on slot 0
        base = cap_n; d0 = done_cnt; a0 = all_cnt; s10 = s1_cnt;
        setup_slot(0, pa, 3, 32'h2);
        setup_slot(1, pb, 4, 32'h0);
        reg_write(8'h04, 32'd100);
        reg_write(8'h00, 32'h21);
        wait_done(d0, "R7");
        check_eq("R7 last flag byte count", 64'(cap_n - base), 3);
        reg_read(slot_reg(1, 'h08), r); check_eq("R7 slot1 untouched", 64'(r), 0);
        reg_read(slot_reg(1, 'h10), r); check_eq("R7 slot1 sent zero", 64'(r), 0);
        check_eq("R10 no all empty", 64'(all_cnt), 64'(a0));
        check_eq("R7 no slot1 event", 64'(s1_cnt), 64'(s10));

        // R8 wait while slot empty
        base = cap_n; d0 = done_cnt; r0 = mem_reads;
        pa = 64'h0000_0000_0000_3000;
        setup_slot(0, pa, 5, 32'h1);
        reg_write(8'h04, 32'd100);
        reg_write(8'h00, 32'h11);
        repeat (30) @(negedge clk);
        check_eq("R8 no bytes while empty", 64'(cap_n - base), 0);
        check_eq("R8 no fetch while empty", 64'(mem_reads - r0), 0);
        reg_read(8'h00, r); check_eq("R8 still enabled", 64'(r[0]), 1);
        reg_write(slot_reg(0, 'h08), 32'h0);
        wait_done(d0, "R8");
        check_eq("R8 bytes after release", 64'(cap_n - base), 5);
        cmp_bytes("R8", base, pa, 0, 5, 0);

        // R9 abort during transfer
        base = cap_n; d0 = done_cnt; ab0 = abort_cnt;
        slow_ready = 1;
        setup_slot(0, 64'h7700, 60, 32'h0);
        reg_write(8'h04, 32'd100);
        reg_write(8'h00, 32'h11);
        k = 0;
        while (cap_n - base < 4 && k < 3000) begin
            @(negedge clk);
            k++;
        end
        skip_hold = 1;
        reg_write(8'h00, 32'h13);
        repeat (3) @(negedge clk);
        check_eq("R9 abort event", 64'(abort_cnt), 64'(ab0 + 1));
        check_eq("R9 no done", 64'(done_cnt), 64'(d0));
        check_eq("R9 tx_valid low", 64'(tx_valid), 0);
        reg_read(8'h00, r); check_eq("R9 enable cleared", 64'(r[0]), 0);
        k = cap_n;
        repeat (20) @(negedge clk);
        check_eq("R9 traffic stopped", 64'(cap_n), 64'(k));
        reg_read(slot_reg(0, 'h10), r);
        check_eq("R4 sent matches accepted", 64'(r), 64'(cap_n - base));
        skip_hold = 0;
        slow_ready = 0;

        // R9 abort while idle
        ab0 = abort_cnt;
        reg_write(8'h00, 32'h12);
        repeat (3) @(negedge clk);
        check_eq("R9 idle abort no event", 64'(abort_cnt), 64'(ab0));
        reg_read(8'h00, r); check_eq("R9 idle abort stays disabled", 64'(r[0]), 0);

        // R4 restart zeroes counters
        run_single(64'h9900, 6, 100, 0);

        // R11 handshake hold
        check_eq("R11 hold violations", 64'(hold_bad), 0);
        check_eq("R11 hold cases seen", 64'(hold_checks > 0), 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule